// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block sits in front of a burst-capable synchronous SRAM array and decides, on every rising clock edge, which word address the array uses. A burst is launched by either of two active-low strobes: one driven by a processor and one driven by a cache controller. When a burst starts, the full incoming word address is captured. After that the two lowest address bits step through a four-beat sequence while the upper bits stay fixed.

The beat order is chosen by a static mode input. With it low the low bits count upward and wrap modulo four. With it high the start bits are XORed with the beat number. An active-low advance input either moves the burst to its next beat or holds the current address, which is how wait states are inserted.

Burst starts are qualified by a group of five chip-enable pins. The block reports whether the array is currently selected. It also reports, for one cycle, that the access just launched came from the processor strobe and is therefore a read, so that downstream write gating can block it.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears mem_addr to zero and drives selected and start_by_proc low.
- R2: A start with all enables active means either qualified strobe low together with ce_main_n low, both ce_hi bits high and both ce_lo_n bits low. After the edge of such a start, mem_addr equals the sampled addr_in and selected is high.
- R3: With mode_ilv low, the k-th advance after a start presents low bits (s + k) mod 4, where s is the start value of addr_in[1:0]. Bits above bit 1 do not change between starts.
- R4: With mode_ilv high, the k-th advance after a start presents low bits s XOR (k mod 4).
- R5: An edge with both strobes high and adv_n high leaves mem_addr unchanged (wait state). An edge with both strobes high and adv_n low moves to the next beat.
- R6: A start with any of the five enables inactive drives selected low on the next cycle and leaves mem_addr unchanged.
- R7: While ce_main_n is high, a low pstrobe_n with cstrobe_n high is ignored. The edge then behaves as a hold or an advance according to adv_n, and selected keeps its value.
- R8: A low cstrobe_n while ce_main_n is high deselects the block (selected low next cycle).
- R9: start_by_proc is high for exactly the cycle after a selected start launched by pstrobe_n. It is low after a controller start, after a deselecting start and after any non-start edge.
- R10: When both strobes are low with all enables active, the processor strobe wins and start_by_proc goes high.
- R11: After four advances the burst wraps to its start address, in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_ilv | input | 1 | Static beat order: 0 = linear, 1 = XOR-interleaved |
| addr_in | input | ADDR_W | External word address |
| pstrobe_n | input | 1 | Processor burst-start strobe, active low |
| cstrobe_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Advance to next beat when low, hold when high |
| ce_main_n | input | 1 | Primary chip enable, active low; also gates pstrobe_n |
| ce_hi | input | NPOS | Secondary enables, active high |
| ce_lo_n | input | NNEG | Secondary enables, active low |
| mem_addr | output | ADDR_W | Word address presented to the array |
| selected | output | 1 | Array selected by the last qualifying start |
| start_by_proc | output | 1 | Access launched this cycle by the processor strobe (read only) |

## Verification
Every combination of the two orders, the four start values of the low bits and three upper-bit patterns is run as a full five-advance burst. These runs separate the linear order from the XOR order: the two differ whenever the start bits are 01 or 11. They also show the modulo-four wrap and whether the upper bits leak. A wait state in the middle of each burst tells a held beat apart from an advanced one.

Each enable pin is made inactive in turn during a start, which isolates each term of the select condition. A separate sequence drives the processor strobe with the primary enable high. The same sequence also drives both strobes together, which distinguishes "ignored" from "deselect" and checks the strobe priority.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Linear order: count upward, wrapping inside the four-word block
  function automatic beat_t lin_beat(input beat_t s, input beat_t k);
    return beat_t'(s + k);
  endfunction

  // Interleaved order: start bits XOR beat number
  function automatic beat_t ilv_beat(input beat_t s, input beat_t k);
    return s ^ k;
  endfunction

  function automatic beat_t burst_low(input logic ilv, input beat_t s, input beat_t k);
    return ilv ? ilv_beat(s, k) : lin_beat(s, k);
  endfunction
endpackage

// File: rtl/bas_start_qual.sv
module bas_start_qual #(
  parameter int NPOS = 2,
  parameter int NNEG = 2
) (
  input  logic            pstrobe_n,
  input  logic            cstrobe_n,
  input  logic            ce_main_n,
  input  logic [NPOS-1:0] ce_hi,
  input  logic [NNEG-1:0] ce_lo_n,
  output logic            start_evt,
  output logic            proc_go,
  output logic            en_ok
);
  logic pos_ok, neg_ok, ctrl_go;

  // Per-pin qualification kept as separate wires so each term is visible
  logic [NPOS-1:0] pos_bit;
  logic [NNEG-1:0] neg_bit;
  genvar gi;
  generate
    for (gi = 0; gi < NPOS; gi++) begin : g_pos
      assign pos_bit[gi] = ce_hi[gi];
    end
    for (gi = 0; gi < NNEG; gi++) begin : g_neg
      assign neg_bit[gi] = ~ce_lo_n[gi];
    end
  endgenerate

  assign pos_ok    = &pos_bit;
  assign neg_ok    = &neg_bit;
  assign en_ok     = ~ce_main_n & pos_ok & neg_ok;
  // Processor strobe only counts while the primary enable is active
  assign proc_go   = ~pstrobe_n & ~ce_main_n;
  // Controller strobe acts only when the processor strobe has not won
  assign ctrl_go   = ~cstrobe_n & ~proc_go;
  assign start_evt = proc_go | ctrl_go;
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clear,
  input  logic  step,
  output beat_t beat
);
  always_ff @(posedge clk) begin
    if (rst)        beat <= '0;
    else if (clear) beat <= '0;
    else if (step)  beat <= beat_t'(beat + 1'b1);
  end
endmodule

// File: rtl/bas_addr_reg.sv
module bas_addr_reg
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ilv,
  input  beat_t             beat,
  output logic [ADDR_W-1:0] mem_addr
);
  logic [ADDR_W-1:0] base_q;
  beat_t             low_now;

  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= addr_in;
  end

  assign low_now = burst_low(ilv, base_q[BEAT_W-1:0], beat);

  generate
    if (ADDR_W > BEAT_W) begin : g_upper
      assign mem_addr = {base_q[ADDR_W-1:BEAT_W], low_now};
    end else begin : g_narrow
      assign mem_addr = low_now;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NPOS   = 2,
  parameter int NNEG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              pstrobe_n,
  input  logic              cstrobe_n,
  input  logic              adv_n,
  input  logic              ce_main_n,
  input  logic [NPOS-1:0]   ce_hi,
  input  logic [NNEG-1:0]   ce_lo_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              selected,
  output logic              start_by_proc
);
  logic  start_evt, proc_go, en_ok;
  logic  load_ok, step_ok;
  beat_t beat;

  bas_start_qual #(.NPOS(NPOS), .NNEG(NNEG)) u_qual (
    .pstrobe_n (pstrobe_n),
    .cstrobe_n (cstrobe_n),
    .ce_main_n (ce_main_n),
    .ce_hi     (ce_hi),
    .ce_lo_n   (ce_lo_n),
    .start_evt (start_evt),
    .proc_go   (proc_go),
    .en_ok     (en_ok)
  );

  assign load_ok = start_evt & en_ok;
  assign step_ok = ~start_evt & ~adv_n;

  bas_beat_ctr u_ctr (
    .clk   (clk),
    .rst   (rst),
    .clear (load_ok),
    .step  (step_ok),
    .beat  (beat)
  );

  bas_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk      (clk),
    .rst      (rst),
    .load     (load_ok),
    .addr_in  (addr_in),
    .ilv      (mode_ilv),
    .beat     (beat),
    .mem_addr (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      selected      <= 1'b0;
      start_by_proc <= 1'b0;
    end else if (start_evt) begin
      selected      <= en_ok;
      start_by_proc <= proc_go & en_ok;
    end else begin
      start_by_proc <= 1'b0;
    end
  end
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_ilv,
  input logic [ADDR_W-1:0] addr_in,
  input logic              pstrobe_n,
  input logic              cstrobe_n,
  input logic              adv_n,
  input logic              ce_main_n,
  input logic              start_evt,
  input logic              proc_go,
  input logic              en_ok,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              selected,
  input logic              start_by_proc
);
  a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
    (start_evt && en_ok) |=> (selected && mem_addr == $past(addr_in)));

  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    !start_evt |=> (mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!start_evt && adv_n) |=> (!$stable(mode_ilv) || $stable(mem_addr)));

  a_r6_deselect: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !en_ok) |=> (!selected && (!$stable(mode_ilv) || $stable(mem_addr))));

  a_r7_proc_ignored: assert property (@(posedge clk) disable iff (rst)
    (ce_main_n && !pstrobe_n && cstrobe_n) |=> $stable(selected));

  a_r8_ctrl_deselect: assert property (@(posedge clk) disable iff (rst)
    (ce_main_n && !cstrobe_n) |=> !selected);

  a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
    (proc_go && en_ok) |=> start_by_proc);

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
    !(proc_go && en_ok) |=> !start_by_proc);

  a_r9_flag_sel: assert property (@(posedge clk) disable iff (rst)
    start_by_proc |-> selected);
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_ilv      (mode_ilv),
  .addr_in       (addr_in),
  .pstrobe_n     (pstrobe_n),
  .cstrobe_n     (cstrobe_n),
  .adv_n         (adv_n),
  .ce_main_n     (ce_main_n),
  .start_evt     (start_evt),
  .proc_go       (proc_go),
  .en_ok         (en_ok),
  .mem_addr      (mem_addr),
  .selected      (selected),
  .start_by_proc (start_by_proc)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_ilv = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          pstrobe_n = 1'b1, cstrobe_n = 1'b1, adv_n = 1'b1;
  logic          ce_main_n = 1'b0;
  logic [1:0]    ce_hi = 2'b11;
  logic [1:0]    ce_lo_n = 2'b00;
  logic [AW-1:0] mem_addr;
  logic          selected, start_by_proc;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .mode_ilv(mode_ilv), .addr_in(addr_in),
    .pstrobe_n(pstrobe_n), .cstrobe_n(cstrobe_n), .adv_n(adv_n),
    .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .mem_addr(mem_addr), .selected(selected), .start_by_proc(start_by_proc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // One clock: drive strobes at the falling edge, sample after the rising edge
  task automatic cyc(input logic p, input logic c, input logic a);
    @(negedge clk);
    pstrobe_n = p; cstrobe_n = c; adv_n = a;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s, input int k);
    int v;
    if (m) v = s ^ (k % 4);
    else   v = (s + k) % 4;
    return v[1:0];
  endfunction

  task automatic enables_on();
    ce_main_n = 1'b0; ce_hi = 2'b11; ce_lo_n = 2'b00;
  endtask

  initial begin
    logic [AW-1:0] a_prev;
    logic [13:0]   upv;
    // R1: reset state
    cyc(1, 1, 1);
    cyc(1, 1, 1);
    chk("R1 mem_addr", mem_addr, 0);
    chk("R1 selected", selected, 0);
    chk("R1 start_by_proc", start_by_proc, 0);
    rst = 1'b0;

    // R2, R3, R4, R5, R11: sweep orders, start bits and upper patterns
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int u = 0; u < 3; u++) begin
          upv = (u == 0) ? 14'h0000 : (u == 1) ? 14'h3FFF : 14'h1A5C;
          mode_ilv = m[0];
          addr_in  = {upv, s[1:0]};
          if (((s + u) % 2) == 0) cyc(0, 1, 1);
          else                    cyc(1, 0, 1);
          chk("R2 start addr", mem_addr, {upv, s[1:0]});
          chk("R2 selected", selected, 1);
          chk("R9 start flag", start_by_proc, (((s + u) % 2) == 0) ? 1 : 0);
          addr_in = ~addr_in;
          for (int k = 1; k <= 5; k++) begin
            cyc(1, 1, 0);
            if (m == 0) chk("R3 linear beat", mem_addr, {upv, exp_low(1'b0, s[1:0], k)});
            else        chk("R4 interleaved beat", mem_addr, {upv, exp_low(1'b1, s[1:0], k)});
            if (k == 1) chk("R9 flag clears", start_by_proc, 0);
            if (k == 4) chk("R11 wrap to start", mem_addr, {upv, s[1:0]});
            if (k == 2) begin
              cyc(1, 1, 1);
              chk("R5 hold", mem_addr, {upv, exp_low(m[0], s[1:0], 2)});
            end
          end
        end
      end
    end

    // R6, R8: each enable inactive in turn during a start
    mode_ilv = 1'b0;
    for (int e = 0; e < 5; e++) begin
      enables_on();
      addr_in = 16'h4C21 + 16'(e * 4);
      cyc(1, 0, 1);
      a_prev = mem_addr;
      chk("R6 pre-select", selected, 1);
      addr_in = 16'h9990;
      case (e)
        0: ce_main_n = 1'b1;
        1: ce_hi[0]  = 1'b0;
        2: ce_hi[1]  = 1'b0;
        3: ce_lo_n[0] = 1'b1;
        default: ce_lo_n[1] = 1'b1;
      endcase
      if (e == 1 || e == 3) cyc(0, 1, 1);
      else                  cyc(1, 0, 1);
      if (e == 0) chk("R8 ctrl deselect", selected, 0);
      else        chk("R6 deselect", selected, 0);
      chk("R6 addr kept", mem_addr, a_prev);
      chk("R9 no flag on deselect", start_by_proc, 0);
    end

    // R7: processor strobe ignored while primary enable is high
    enables_on();
    addr_in = 16'h7776;
    cyc(1, 0, 1);
    ce_main_n = 1'b1;
    addr_in = 16'h0001;
    cyc(0, 1, 1);
    chk("R7 hold addr", mem_addr, 16'h7776);
    chk("R7 selected kept", selected, 1);
    chk("R7 no flag", start_by_proc, 0);
    cyc(0, 1, 0);
    chk("R7 advances", mem_addr, 16'h7777);
    chk("R7 selected kept 2", selected, 1);

    // R10: both strobes low, processor wins
    enables_on();
    addr_in = 16'h3002;
    cyc(0, 0, 1);
    chk("R10 addr", mem_addr, 16'h3002);
    chk("R10 flag", start_by_proc, 1);
    cyc(1, 0, 1);
    chk("R9 ctrl start no flag", start_by_proc, 0);

    // R1: reset in the middle of a burst
    cyc(1, 1, 0);
    rst = 1'b1;
    cyc(0, 1, 1);
    chk("R1 mid reset addr", mem_addr, 0);
    chk("R1 mid reset selected", selected, 0);
    chk("R1 mid reset flag", start_by_proc, 0);
    rst = 1'b0;
    cyc(1, 1, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule